// File: doc/BRIEF.md
# Touch ADC Conversion Trigger Generator

This block decides when a touchscreen ADC sequencer starts a conversion. It emits a one-cycle start pulse. The trigger source comes from a 3-bit mode field in a 32-bit trigger control word. The sources are:

- nothing;
- a rising, falling or any edge on an asynchronous external trigger pin;
- a pen-contact event;
- a periodic timer whose interval sits in the upper half of the same word;
- continuous triggering, where each conversion is started as soon as the previous one ends.

A separate two-bit command write can force one conversion at any time. The same write can also return the block to its idle, untriggered state.

The external pin is brought into the clock domain through a synchroniser chain before edge detection. Every write of the control word restarts the timer and discards any edge still travelling through the synchroniser. A mode change therefore never produces a pulse from an event that happened under the previous configuration. The sequencer only has to accept the start pulse and report its busy state back.

Top module: `touch_trig_gen`

## Requirements
- R1: A write (`cfg_wr`) loads the mode from `cfg_wdata[2:0]` and the period from `cfg_wdata[31:16]`; bits [15:3] are ignored. The new mode governs triggers from the cycle after the write.
- R2: In mode 0 (off) and mode 7 (reserved), the external pin, pen events, the timer and the busy input produce no start pulse.
- R3: In mode 1 a low-to-high change of `ext_trig_in` gives a start pulse, in mode 2 a high-to-low change does, and in mode 3 either change does. The pulse appears in the third cycle after the cycle in which the pin changed, with the default two synchroniser stages.
- R4: In mode 4 a `pen_evt` high in cycle k gives a start pulse in cycle k+1. In every other mode `pen_evt` is ignored.
- R5: In mode 5 with period P, counting the write cycle as cycle 0, pulses appear in cycles P+1, 2P+1, 3P+1 and so on. P = 0 behaves as P = 1.
- R6: In mode 6 a pulse appears in the cycle after the first cycle in which `conv_busy` is low following a high. If `conv_busy` is low when the mode is entered, one pulse appears in cycle 2 after the write.
- R7: A command write (`ctl_wr`) with bit 1 set and bit 0 clear gives a start pulse in the next cycle, in any mode.
- R8: A command write with bit 0 set sets the mode and period to 0 and clears the timer, the edge history and any pending continuous start. No pulse follows in the next cycle, even if bit 1 is also set.
- R9: A control word write restarts the timer from zero and discards edges that reached the pin in or before the write cycle. No mode-driven pulse follows the write cycle.
- R10: `start_o` is low while `rst_n` is low and in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the trigger control word |
| cfg_wdata | input | 32 | Trigger control word: mode [2:0], period [31:16] |
| ctl_wr | input | 1 | Write strobe for the command bits |
| ctl_wdata | input | 2 | Command: bit 0 idle-reset, bit 1 single start |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| pen_evt | input | 1 | One-cycle pen-contact event |
| conv_busy | input | 1 | High while the ADC converts |
| start_o | output | 1 | Start-of-conversion pulse |

## Verification
The bound checker watches every cycle for these properties:

- the next-cycle response to a pen event in pen mode;
- a software start;
- an idle-reset command;
- the end of busy in continuous mode;
- silence in the off and reserved modes;
- silence after any control write.

Only the bench scenarios can show the exact three-cycle latency of each external edge polarity and the spacing of timer pulses for several periods, including zero. They also show that rewriting the word restarts the timer, and that an edge arriving with the mode write is discarded.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

   localparam int MODE_W = 3;
   localparam int CTL_W = 2;
   localparam int CTL_IDLE_BIT = 0;
   localparam int CTL_GO_BIT = 1;

   typedef enum logic [MODE_W-1:0] {
      TM_OFF      = 3'd0,
      TM_EXT_RISE = 3'd1,
      TM_EXT_FALL = 3'd2,
      TM_EXT_BOTH = 3'd3,
      TM_PEN      = 3'd4,
      TM_TIMER    = 3'd5,
      TM_CONT     = 3'd6,
      TM_RSVD     = 3'd7
   } trig_mode_e;

endpackage

// File: rtl/tt_sync_chain.sv
module tt_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("tt_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tt_edge_det.sv
module tt_edge_det #(
   parameter int BLANK = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic rise,
   output logic fall
);

   localparam int BW = $clog2(BLANK + 1);

   generate
      if (BLANK < 1) begin : g_bad
         $error("tt_edge_det: BLANK must be at least 1");
      end
   endgenerate

   logic          prev_q;
   logic [BW-1:0] blank_q;
   logic          open_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            blank_q <= '0;
      else if (clr)          blank_q <= BW'(BLANK);
      else if (blank_q != 0) blank_q <= blank_q - 1'b1;
   end

   assign open_w = (blank_q == '0);
   assign rise   = open_w &  d & ~prev_q;
   assign fall   = open_w & ~d &  prev_q;

endmodule

// File: rtl/tt_period_timer.sv
module tt_period_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);

   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] last_w;
   logic                hit_w;

   assign last_w = (period == '0) ? '0 : period - 1'b1;
   assign hit_w  = (cnt_q >= last_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr || !en) cnt_q <= '0;
      else if (hit_w)      cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   assign tick = en & hit_w;

endmodule

// File: rtl/touch_trig_gen.sv
module touch_trig_gen
   import tsg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int MODE_LSB    = 0,
   parameter int PERIOD_LSB  = 16,
   parameter int PERIOD_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              ext_trig_in,
   input  logic              pen_evt,
   input  logic              conv_busy,
   output logic              start_o
);

   generate
      if (PERIOD_LSB + PERIOD_W > DATA_W) begin : g_bad_period
         $error("touch_trig_gen: period field exceeds control word");
      end
      if (MODE_LSB + MODE_W > PERIOD_LSB) begin : g_bad_mode
         $error("touch_trig_gen: mode field overlaps period field");
      end
   endgenerate

   trig_mode_e          mode_q;
   logic [PERIOD_W-1:0] period_q;
   trig_mode_e          new_mode_w;
   logic                idle_cmd_w;
   logic                go_cmd_w;
   logic                clr_w;
   logic                ext_s_w;
   logic                ext_rise_w;
   logic                ext_fall_w;
   logic                tick_w;
   logic                busy_d_q;
   logic                kick_q;
   logic                cont_fire_w;
   logic                mode_trig_w;

   assign new_mode_w = trig_mode_e'(cfg_wdata[MODE_LSB +: MODE_W]);
   assign idle_cmd_w = ctl_wr & ctl_wdata[CTL_IDLE_BIT];
   assign go_cmd_w   = ctl_wr & ctl_wdata[CTL_GO_BIT] & ~ctl_wdata[CTL_IDLE_BIT];
   assign clr_w      = cfg_wr | idle_cmd_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= TM_OFF;
         period_q <= '0;
      end else if (idle_cmd_w) begin
         mode_q   <= TM_OFF;
         period_q <= '0;
      end else if (cfg_wr) begin
         mode_q   <= new_mode_w;
         period_q <= cfg_wdata[PERIOD_LSB +: PERIOD_W];
      end
   end

   tt_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_trig_in),
      .q     (ext_s_w)
   );

   tt_edge_det #(.BLANK(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_w),
      .d     (ext_s_w),
      .rise  (ext_rise_w),
      .fall  (ext_fall_w)
   );

   tt_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_w),
      .en     (mode_q == TM_TIMER),
      .period (period_q),
      .tick   (tick_w)
   );

   assign cont_fire_w = (mode_q == TM_CONT) & ~conv_busy & (busy_d_q | kick_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_d_q <= 1'b0;
      else        busy_d_q <= conv_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           kick_q <= 1'b0;
      else if (idle_cmd_w)  kick_q <= 1'b0;
      else if (cfg_wr)      kick_q <= (new_mode_w == TM_CONT);
      else if (cont_fire_w) kick_q <= 1'b0;
   end

   always_comb begin
      case (mode_q)
         TM_EXT_RISE: mode_trig_w = ext_rise_w;
         TM_EXT_FALL: mode_trig_w = ext_fall_w;
         TM_EXT_BOTH: mode_trig_w = ext_rise_w | ext_fall_w;
         TM_PEN:      mode_trig_w = pen_evt;
         TM_TIMER:    mode_trig_w = tick_w;
         TM_CONT:     mode_trig_w = cont_fire_w;
         default:     mode_trig_w = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_o <= 1'b0;
      else        start_o <= go_cmd_w | (mode_trig_w & ~clr_w);
   end

endmodule

// File: rtl/touch_trig_gen_chk.sv
module touch_trig_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_wr,
   input logic       ctl_wr,
   input logic [1:0] ctl_wdata,
   input logic       pen_evt,
   input logic       conv_busy,
   input logic       start_o,
   input logic [2:0] mode_q
);

   logic go_w;
   logic idle_w;
   assign go_w   = ctl_wr & ctl_wdata[1] & ~ctl_wdata[0];
   assign idle_w = ctl_wr & ctl_wdata[0];

   a_r10_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !start_o);

   a_r4_pen_next: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd4 && pen_evt && !cfg_wr && !idle_w) |=> start_o);

   a_r7_sw_go: assert property (@(posedge clk) disable iff (!rst_n)
      go_w |=> start_o);

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle_w |=> !start_o);

   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 3'd0 || mode_q == 3'd7) && !go_w) |=> !start_o);

   a_r6_cont_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && mode_q == 3'd6 && $fell(conv_busy) && !cfg_wr && !idle_w)
      |=> start_o);

   a_r9_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !go_w) |=> !start_o);

endmodule

bind touch_trig_gen touch_trig_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .ctl_wr    (ctl_wr),
   .ctl_wdata (ctl_wdata),
   .pen_evt   (pen_evt),
   .conv_busy (conv_busy),
   .start_o   (start_o),
   .mode_q    (mode_q)
);

// File: tb/sim_touch_trig_gen.sv
module sim_touch_trig_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        ctl_wr = 1'b0;
   logic [1:0]  ctl_wdata = '0;
   logic        ext_trig_in = 1'b0;
   logic        pen_evt = 1'b0;
   logic        conv_busy = 1'b0;
   logic        start_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   touch_trig_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ext_trig_in(ext_trig_in),
      .pen_evt(pen_evt), .conv_busy(conv_busy), .start_o(start_o)
   );

   // stim: 0 none, 1 ext high t4..t8, 2 pen at t4, 3 busy high t4..t7, 4 ext low from t4
   typedef struct packed {
      logic [2:0]  mode;
      logic [15:0] per;
      logic [2:0]  stim;
      logic [7:0]  cnt;
      logic [7:0]  first;
   } vec_t;

   localparam int NV = 16;
   localparam int WIN = 40;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 16'd0,  3'd1, 8'd0,  8'd255},
      '{3'd1, 16'd0,  3'd1, 8'd1,  8'd7},
      '{3'd2, 16'd0,  3'd1, 8'd1,  8'd12},
      '{3'd3, 16'd0,  3'd1, 8'd2,  8'd7},
      '{3'd4, 16'd0,  3'd2, 8'd1,  8'd5},
      '{3'd1, 16'd0,  3'd2, 8'd0,  8'd255},
      '{3'd4, 16'd0,  3'd1, 8'd0,  8'd255},
      '{3'd7, 16'd0,  3'd2, 8'd0,  8'd255},
      '{3'd7, 16'd0,  3'd1, 8'd0,  8'd255},
      '{3'd5, 16'd10, 3'd0, 8'd3,  8'd10},
      '{3'd5, 16'd7,  3'd0, 8'd5,  8'd7},
      '{3'd5, 16'd0,  3'd0, 8'd39, 8'd1},
      '{3'd5, 16'd1,  3'd0, 8'd39, 8'd1},
      '{3'd6, 16'd0,  3'd3, 8'd2,  8'd1},
      '{3'd0, 16'd0,  3'd3, 8'd0,  8'd255},
      '{3'd5, 16'd10, 3'd2, 8'd3,  8'd10}
   };

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd1, 3'd2, 3'd3: return "R3";
         3'd4:             return "R4";
         3'd5:             return "R5";
         3'd6:             return "R6";
         default:          return "R2";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [2:0] m, input logic [15:0] p,
                            input logic [12:0] junk);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = {p, junk, m};
   endtask

   task automatic command(input logic [1:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
   endtask

   task automatic run_window(input int n, input int stim, output int cnt, output int first);
      cnt = 0;
      first = 255;
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         ctl_wr = 1'b0;
         case (stim)
            1: ext_trig_in = (t >= 4 && t < 9);
            2: pen_evt = (t == 4);
            3: conv_busy = (t >= 4 && t < 8);
            4: ext_trig_in = (t < 4);
            default: ;
         endcase
         if (start_o) begin
            if (cnt == 0) first = t;
            cnt++;
         end
      end
   endtask

   initial begin
      int c, f;
      repeat (3) @(negedge clk);
      check(start_o == 1'b0, "R10", start_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(start_o == 1'b0, "R10", start_o, 0);

      for (int i = 0; i < NV; i++) begin
         write_cfg(VEC[i].mode, VEC[i].per, 13'd0);
         run_window(WIN, int'(VEC[i].stim), c, f);
         check(c == int'(VEC[i].cnt), req_of(VEC[i].mode), c, int'(VEC[i].cnt));
         check(f == int'(VEC[i].first), req_of(VEC[i].mode), f, int'(VEC[i].first));
      end

      // R7: single start in off mode
      write_cfg(3'd0, 16'd0, 13'd0);
      run_window(3, 0, c, f);
      command(2'b10);
      run_window(3, 0, c, f);
      check(c == 1 && f == 0, "R7", f, 0);

      // R8: idle command stops a running timer
      write_cfg(3'd5, 16'd3, 13'd0);
      run_window(5, 0, c, f);
      command(2'b01);
      run_window(20, 0, c, f);
      check(c == 0, "R8", c, 0);
      // R8: idle command wins over a simultaneous start
      command(2'b11);
      run_window(3, 0, c, f);
      check(c == 0, "R8", c, 0);

      // R9: rewrite restarts timer
      write_cfg(3'd5, 16'd10, 13'd0);
      run_window(15, 0, c, f);
      check(c == 1 && f == 10, "R9", f, 10);
      write_cfg(3'd5, 16'd10, 13'd0);
      run_window(30, 0, c, f);
      check(f == 10, "R9", f, 10);
      check(c == 2, "R9", c, 2);

      // R9: edge arriving with the write is discarded
      write_cfg(3'd0, 16'd0, 13'd0);
      run_window(4, 0, c, f);
      write_cfg(3'd1, 16'd0, 13'd0);
      ext_trig_in = 1'b1;
      run_window(20, 0, c, f);
      check(c == 0, "R9", c, 0);
      write_cfg(3'd3, 16'd0, 13'd0);
      run_window(20, 4, c, f);
      check(c == 1 && f == 7, "R3", f, 7);

      // R1: bits [15:3] ignored
      write_cfg(3'd5, 16'd10, 13'h1FFF);
      run_window(15, 0, c, f);
      check(c == 1 && f == 10, "R1", f, 10);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule